// File: doc/BRIEF.md
# SPI Channel Register, FIFO and Interrupt Front End

This block sits between a 32-bit memory-mapped register bus and the serial shift engine of one SPI channel. Software programs the channel's configuration and clock divider words, loads outgoing words into a transmit FIFO, writes a command word to launch a transfer, and drains incoming words from a receive FIFO. The shift engine pops the transmit FIFO, pushes the receive FIFO, and reports completion with a one-cycle pulse. The serializer itself is not part of this block.

A six-bit sticky status register collects events: transfer pending, transfer done, transmit-level and receive-level threshold hits, transmit underflow and receive overflow. Software clears status bits by writing ones. A five-bit enable register selects which of the five event bits raise the level interrupt output. A small command sequencer tracks each transfer through three states: `CMD_IDLE` (no transfer; a command write is accepted and moves to `CMD_LAUNCH`), `CMD_LAUNCH` (the start strobe is high for exactly this one cycle; always moves to `CMD_WAIT`) and `CMD_WAIT` (waits for the engine's done pulse, which returns it to `CMD_IDLE`).

Register offsets: 0x00 configuration, 0x04 divider, 0x08 command, 0x0C status, 0x10 interrupt enable, 0x14 threshold, 0x18 word counts, 0x1C transmit data (write), 0x20 receive data (read). Unmapped offsets read zero. Read data is a combinational function of the address; a bus access takes effect at the clock edge that ends the cycle in which `bus_sel` is high.

Top module: `spi_chan_regs`

## Requirements
- R1: While reset is asserted both FIFOs are empty, the status and enable registers are zero, the threshold register is 0x80, `irq` and `eng_start` are low, and `eng_tx_avail` is low.
- R2: A write to 0x1C appends the word to the transmit FIFO; `eng_tx_avail` is high while it holds a word, `eng_tx_word` shows the oldest word, and `eng_tx_pop` removes it. Offset 0x18 reports the transmit count in bits [7:4].
- R3: A write to 0x1C while the transmit FIFO holds 8 words is dropped and sets status bit 4; an `eng_tx_pop` while it is empty also sets status bit 4.
- R4: `eng_rx_push` appends `eng_rx_word` to the receive FIFO; a read of 0x20 returns the oldest word and removes it; offset 0x18 reports the receive count in bits [3:0]; a read of 0x20 with the FIFO empty returns zero and changes no count.
- R5: An `eng_rx_push` while the receive FIFO holds 8 words is dropped and sets status bit 5.
- R6: Writing 0x0C clears each status bit written with 1 and keeps each bit written with 0; an event that sets a bit in the same cycle as its clear wins.
- R7: Threshold register bits [3:0] give the transmit level and bits [7:4] the receive level; at every clock edge status bit 2 is set if the transmit count is at or below its level and status bit 3 is set if the receive count is at or above its level, counts taken before that edge.
- R8: A write to 0x08 in `CMD_IDLE` stores the command word (read back at 0x08, driven on `eng_cmd`), sets status bit 0, and raises `eng_start` for exactly the next cycle; a write to 0x08 in any other state is ignored.
- R9: An `eng_done` pulse sets status bit 1, clears status bit 0, and returns the sequencer from `CMD_WAIT` to `CMD_IDLE`.
- R10: `irq` is high whenever a status bit is set whose enable bit is set, with enable bit 0 gating status bit 1, enable bit 1 status bit 2, enable bit 2 status bit 3, enable bit 3 status bit 4 and enable bit 4 status bit 5; status bit 0 never raises `irq`.
- R11: Offsets 0x00 and 0x04 are plain read/write words driven on `eng_cfg` and `eng_div`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |
| eng_cfg | output | 32 | Configuration word to the engine |
| eng_div | output | 32 | Divider word to the engine |
| eng_cmd | output | 32 | Last accepted command word |
| eng_start | output | 1 | One-cycle transfer start strobe |
| eng_tx_word | output | 32 | Oldest transmit FIFO word |
| eng_tx_avail | output | 1 | Transmit FIFO not empty |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_word | input | 32 | Received word |
| eng_done | input | 1 | Transfer-complete pulse from the engine |

## Verification
The hardest situation to reach is a status event and its write-one clear landing on the same clock edge, because it needs an engine pulse and a bus write aligned to one cycle against an already full receive FIFO. The stimulus fills the receive FIFO to its limit first, then holds `eng_rx_push` high during the status write cycle so the overflow and the clear meet. A behavioural model with queues follows the block on every clock, so threshold flags, which depend on counts before each edge, are compared in every cycle of every scenario rather than at hand-picked points.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
    localparam int BUS_AW = 8;

    localparam logic [BUS_AW-1:0] OFF_CFG  = 8'h00;
    localparam logic [BUS_AW-1:0] OFF_DIV  = 8'h04;
    localparam logic [BUS_AW-1:0] OFF_CMD  = 8'h08;
    localparam logic [BUS_AW-1:0] OFF_STAT = 8'h0C;
    localparam logic [BUS_AW-1:0] OFF_IEN  = 8'h10;
    localparam logic [BUS_AW-1:0] OFF_THR  = 8'h14;
    localparam logic [BUS_AW-1:0] OFF_CNT  = 8'h18;
    localparam logic [BUS_AW-1:0] OFF_TXD  = 8'h1C;
    localparam logic [BUS_AW-1:0] OFF_RXD  = 8'h20;

    // status bit positions (software decodes these)
    localparam int ST_PEND = 0;
    localparam int ST_DONE = 1;
    localparam int ST_TXLV = 2;
    localparam int ST_RXLV = 3;
    localparam int ST_TXUF = 4;
    localparam int ST_RXOF = 5;
    localparam int ST_W    = 6;
    localparam int IEN_W   = 5;
    localparam int THR_W   = 8;
    localparam logic [THR_W-1:0] THR_RST = 8'h80;

    typedef enum logic [1:0] {
        CMD_IDLE   = 2'd0,
        CMD_LAUNCH = 2'd1,
        CMD_WAIT   = 2'd2
    } cmd_state_t;
endpackage

// File: rtl/spi_chan_fifo.sv
module spi_chan_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  logic [WIDTH-1:0]                 push_data,
    input  logic                             pop,
    output logic [WIDTH-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]       count,
    output logic                             full,
    output logic                             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // R3 / R5: a full FIFO never grows past its depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R5: a push into a full FIFO with no pop leaves the count alone
    p_drop_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/spi_chan_seq.sv
module spi_chan_seq
    import spi_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic eng_done,
    output logic accept,
    output logic start
);
    cmd_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CMD_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CMD_IDLE:   if (cmd_wr) state_nx = CMD_LAUNCH;
            CMD_LAUNCH: state_nx = CMD_WAIT;
            CMD_WAIT:   if (eng_done) state_nx = CMD_IDLE;
            default:    state_nx = CMD_IDLE;
        endcase
    end

    always_comb begin
        accept = 1'b0;
        start  = 1'b0;
        unique case (state)
            CMD_IDLE:   accept = cmd_wr;
            CMD_LAUNCH: start  = 1'b1;
            CMD_WAIT:   ;
            default:    ;
        endcase
    end

    // R8: the start strobe lasts one cycle and follows every acceptance
    p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    p_accept_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> start);
endmodule

// File: rtl/spi_chan_regs.sv
module spi_chan_regs
    import spi_chan_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    output logic [DW-1:0]     eng_cfg,
    output logic [DW-1:0]     eng_div,
    output logic [DW-1:0]     eng_cmd,
    output logic              eng_start,
    output logic [DW-1:0]     eng_tx_word,
    output logic              eng_tx_avail,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [DW-1:0]     eng_rx_word,
    input  logic              eng_done
);
    localparam int CW = $clog2(DEPTH+1);

    logic            wr_cfg, wr_div, wr_cmd, wr_stat, wr_ien, wr_thr, wr_txd, rd_rxd;
    logic [CW-1:0]   tx_cnt, rx_cnt;
    logic [3:0]      tx_nib, rx_nib;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic [DW-1:0]   rx_head;
    logic            cmd_acc;
    logic [ST_W-1:0] stat_q, stat_d, stat_set, stat_clr;
    logic [IEN_W-1:0] ien_q;
    logic [THR_W-1:0] thr_q;

    assign wr_cfg  = bus_sel && bus_wr && (bus_addr == OFF_CFG);
    assign wr_div  = bus_sel && bus_wr && (bus_addr == OFF_DIV);
    assign wr_cmd  = bus_sel && bus_wr && (bus_addr == OFF_CMD);
    assign wr_stat = bus_sel && bus_wr && (bus_addr == OFF_STAT);
    assign wr_ien  = bus_sel && bus_wr && (bus_addr == OFF_IEN);
    assign wr_thr  = bus_sel && bus_wr && (bus_addr == OFF_THR);
    assign wr_txd  = bus_sel && bus_wr && (bus_addr == OFF_TXD);
    assign rd_rxd  = bus_sel && !bus_wr && (bus_addr == OFF_RXD);

    spi_chan_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(wr_txd), .push_data(bus_wdata), .pop(eng_tx_pop),
        .head(eng_tx_word), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spi_chan_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(eng_rx_push), .push_data(eng_rx_word), .pop(rd_rxd),
        .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spi_chan_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(wr_cmd), .eng_done(eng_done),
        .accept(cmd_acc), .start(eng_start)
    );

    assign eng_tx_avail = !tx_empty;
    assign tx_nib = 4'(tx_cnt);
    assign rx_nib = 4'(rx_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_cfg <= '0;
            eng_div <= '0;
            eng_cmd <= '0;
            ien_q   <= '0;
            thr_q   <= THR_RST;
        end else begin
            if (wr_cfg)  eng_cfg <= bus_wdata;
            if (wr_div)  eng_div <= bus_wdata;
            if (cmd_acc) eng_cmd <= bus_wdata;
            if (wr_ien)  ien_q   <= bus_wdata[IEN_W-1:0];
            if (wr_thr)  thr_q   <= bus_wdata[THR_W-1:0];
        end
    end

    // sticky status: event sets win over a same-cycle write-one clear
    always_comb begin
        stat_set          = '0;
        stat_set[ST_PEND] = cmd_acc;
        stat_set[ST_DONE] = eng_done;
        stat_set[ST_TXLV] = (tx_nib <= thr_q[3:0]);
        stat_set[ST_RXLV] = (rx_nib >= thr_q[7:4]);
        stat_set[ST_TXUF] = (wr_txd && tx_full) || (eng_tx_pop && tx_empty);
        stat_set[ST_RXOF] = eng_rx_push && rx_full;
        stat_clr          = wr_stat ? bus_wdata[ST_W-1:0] : '0;
        stat_d            = (stat_q & ~stat_clr) | stat_set;
        stat_d[ST_PEND]   = cmd_acc || (stat_q[ST_PEND] && !stat_clr[ST_PEND] && !eng_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // enable bit k gates status bit k+1; pending has no enable
    always_comb begin
        irq = 1'b0;
        for (int k = 0; k < IEN_W; k++) begin
            irq = irq || (stat_q[k+1] && ien_q[k]);
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CFG:  bus_rdata = eng_cfg;
            OFF_DIV:  bus_rdata = eng_div;
            OFF_CMD:  bus_rdata = eng_cmd;
            OFF_STAT: bus_rdata[ST_W-1:0]  = stat_q;
            OFF_IEN:  bus_rdata[IEN_W-1:0] = ien_q;
            OFF_THR:  bus_rdata[THR_W-1:0] = thr_q;
            OFF_CNT:  bus_rdata[7:0] = {tx_nib, rx_nib};
            OFF_RXD:  bus_rdata = rx_empty ? '0 : rx_head;
            default:  bus_rdata = '0;
        endcase
    end

    // R10: the interrupt only rises with some event bit set
    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_q[ST_W-1:1] != '0));
    // R6: a one written to done clears it when no done pulse coincides
    p_w1c_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[ST_DONE] && !eng_done) |=> !stat_q[ST_DONE]);
    // R5: overflow is recorded
    p_rx_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full) |=> stat_q[ST_RXOF]);
    // R9: done pulse drops pending unless a command is accepted in that cycle
    p_done_clears_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !cmd_acc) |=> !stat_q[ST_PEND]);
    // R8: pending is visible during the start strobe
    p_start_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> stat_q[ST_PEND]);
    // R4: empty receive reads return zero
    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && rx_empty) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_spi_chan_regs.sv
module sim_spi_chan_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, eng_start, eng_tx_avail;
    logic [31:0] eng_cfg, eng_div, eng_cmd, eng_tx_word;
    logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0, eng_done = 1'b0;
    logic [31:0] eng_rx_word = '0;

    always #4 clk = ~clk;   // 125 MHz

    spi_chan_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_cfg(eng_cfg), .eng_div(eng_div), .eng_cmd(eng_cmd),
        .eng_start(eng_start), .eng_tx_word(eng_tx_word), .eng_tx_avail(eng_tx_avail),
        .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .eng_rx_word(eng_rx_word),
        .eng_done(eng_done)
    );

    int total = 0, bad = 0;
    bit done_flag = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] q_tx[$], q_rx[$];
    logic [5:0]  m_st;
    logic [4:0]  m_en;
    logic [7:0]  m_thr;
    logic [31:0] m_cfg, m_div, m_cmd;
    int          m_fsm;          // 0 idle, 1 launch, 2 wait
    bit          started = 0;
    int          ntx, nrx;
    bit          acc, txw, rxr, unf, ovf, tlv, rlv;
    logic [5:0]  clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_tx.delete(); q_rx.delete();
            m_st = '0; m_en = '0; m_thr = 8'h80;
            m_cfg = '0; m_div = '0; m_cmd = '0; m_fsm = 0;
        end else begin
            ntx = q_tx.size(); nrx = q_rx.size();
            acc = bus_sel && bus_wr && bus_addr == 8'h08 && m_fsm == 0;
            txw = bus_sel && bus_wr && bus_addr == 8'h1C;
            rxr = bus_sel && !bus_wr && bus_addr == 8'h20;
            unf = (eng_tx_pop && ntx == 0) || (txw && ntx == 8);
            ovf = eng_rx_push && nrx == 8;
            tlv = ntx <= int'(m_thr[3:0]);
            rlv = nrx >= int'(m_thr[7:4]);
            clr = (bus_sel && bus_wr && bus_addr == 8'h0C) ? bus_wdata[5:0] : 6'h0;
            m_st[0] = acc || (m_st[0] && !clr[0] && !eng_done);
            m_st[1] = (m_st[1] && !clr[1]) || eng_done;
            m_st[2] = (m_st[2] && !clr[2]) || tlv;
            m_st[3] = (m_st[3] && !clr[3]) || rlv;
            m_st[4] = (m_st[4] && !clr[4]) || unf;
            m_st[5] = (m_st[5] && !clr[5]) || ovf;
            if (eng_tx_pop && ntx > 0) void'(q_tx.pop_front());
            if (txw && ntx < 8) q_tx.push_back(bus_wdata);
            if (rxr && nrx > 0) void'(q_rx.pop_front());
            if (eng_rx_push && nrx < 8) q_rx.push_back(eng_rx_word);
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    8'h00: m_cfg = bus_wdata;
                    8'h04: m_div = bus_wdata;
                    8'h10: m_en  = bus_wdata[4:0];
                    8'h14: m_thr = bus_wdata[7:0];
                    default: ;
                endcase
            end
            if (acc) m_cmd = bus_wdata;
            case (m_fsm)
                0: if (acc) m_fsm = 1;
                1: m_fsm = 2;
                default: if (eng_done) m_fsm = 0;
            endcase
        end
        started = 1;
    end

    function automatic logic [31:0] model_rd(logic [7:0] a);
        case (a)
            8'h00: return m_cfg;
            8'h04: return m_div;
            8'h08: return m_cmd;
            8'h0C: return {26'h0, m_st};
            8'h10: return {27'h0, m_en};
            8'h14: return {24'h0, m_thr};
            8'h18: return {24'h0, 4'(q_tx.size()), 4'(q_rx.size())};
            8'h20: return (q_rx.size() > 0) ? q_rx[0] : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h00, 8'h04: return "R11 cfg/div readback";
            8'h08: return "R8 cmd readback";
            8'h0C: return "R6/R3/R5/R7/R9 status";
            8'h10: return "R10 enable";
            8'h14: return "R7 threshold";
            8'h18: return "R2/R4 counts";
            8'h20: return "R4 rx data";
            default: return "R11 unmapped";
        endcase
    endfunction

    // compare every output against the model in every cycle
    always @(posedge clk) begin
        #6;
        if (started && !done_flag) begin
            chk(tag_of(bus_addr), bus_rdata, model_rd(bus_addr));
            chk("R10 irq", {31'h0, irq}, {31'h0, |(m_st[5:1] & m_en)});
            chk("R8 eng_start", {31'h0, eng_start}, {31'h0, m_fsm == 1});
            chk("R2 tx_avail", {31'h0, eng_tx_avail}, {31'h0, q_tx.size() > 0});
            if (q_tx.size() > 0) chk("R2 tx_word", eng_tx_word, q_tx[0]);
            chk("R8 eng_cmd", eng_cmd, m_cmd);
            chk("R11 eng_cfg", eng_cfg, m_cfg);
            chk("R11 eng_div", eng_div, m_div);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(); @(posedge clk); #2; endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        step();
        bus_sel = 0;
    endtask

    task automatic rd_expect(logic [7:0] a, logic [31:0] mask, logic [31:0] exp, string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #3;
        chk(tag, bus_rdata & mask, exp);
        step();
        bus_sel = 0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) step();
        // R1: reset state
        bus_addr = 8'h18; #1;
        chk("R1 counts", bus_rdata, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 start", {31'h0, eng_start}, 32'h0);
        chk("R1 tx_avail", {31'h0, eng_tx_avail}, 32'h0);
        bus_addr = 8'h14; #1;
        chk("R1 threshold", bus_rdata, 32'h80);
        bus_addr = 8'h0C; #1;
        chk("R1 status", bus_rdata, 32'h0);
        step();
        rst_n = 1;
        step();

        // R11: plain words
        wr(8'h00, 32'h0000_0A5B);
        wr(8'h04, 32'h0000_0010);
        rd(8'h00); rd(8'h04); rd(8'h3C);
        wr(8'h10, 32'h1F);
        wr(8'h14, 32'h80);

        // R2 fill, R3 ninth word dropped
        for (int i = 0; i < 9; i++) wr(8'h1C, 32'h1000 + i);
        rd_expect(8'h18, 32'hFF, 32'h80, "R2 tx count 8");
        rd_expect(8'h0C, 32'h10, 32'h10, "R3 overflow write sets bit4");

        // R7 threshold flags
        wr(8'h0C, 32'h04);
        rd_expect(8'h0C, 32'h04, 32'h00, "R7 tx level not reached");
        wr(8'h14, 32'h08);
        step();
        rd_expect(8'h0C, 32'h04, 32'h04, "R7 tx level reached");
        wr(8'h14, 32'h42);
        wr(8'h0C, 32'h3F);

        // R8 command, second write ignored
        wr(8'h08, 32'h001F_0003);
        wr(8'h08, 32'hDEAD_0000);
        rd_expect(8'h08, 32'hFFFF_FFFF, 32'h001F_0003, "R8 busy write ignored");

        // engine activity: R2 pops, R4/R5 pushes
        for (int i = 0; i < 4; i++) begin eng_tx_pop = 1; step(); end
        eng_tx_pop = 0;
        for (int i = 0; i < 10; i++) begin
            eng_rx_push = 1; eng_rx_word = 32'h2000 + i; step();
        end
        eng_rx_push = 0;
        rd_expect(8'h18, 32'h0F, 32'h08, "R4 rx count 8");
        rd_expect(8'h0C, 32'h20, 32'h20, "R5 overflow bit5");

        // R9 done
        eng_done = 1; step(); eng_done = 0;
        rd_expect(8'h0C, 32'h03, 32'h02, "R9 done set pending cleared");

        // R6 clear one bit, write of zero
        wr(8'h0C, 32'h02);
        rd_expect(8'h0C, 32'h02, 32'h00, "R6 done cleared");
        wr(8'h0C, 32'h00);
        rd(8'h0C);

        // R4 drain and empty read
        for (int i = 0; i < 8; i++) rd(8'h20);
        rd_expect(8'h20, 32'hFFFF_FFFF, 32'h0, "R4 empty read is zero");
        rd_expect(8'h18, 32'h0F, 32'h00, "R4 count stays zero");

        // R3 engine pops past empty
        wr(8'h0C, 32'h10);
        for (int i = 0; i < 5; i++) begin eng_tx_pop = 1; step(); end
        eng_tx_pop = 0;
        rd_expect(8'h0C, 32'h10, 32'h10, "R3 pop on empty sets bit4");

        // R6 set wins over clear in same cycle
        for (int i = 0; i < 8; i++) begin
            eng_rx_push = 1; eng_rx_word = 32'h3000 + i; step();
        end
        eng_rx_push = 1; eng_rx_word = 32'hBAD0;
        wr(8'h0C, 32'h20);
        eng_rx_push = 0;
        rd_expect(8'h0C, 32'h20, 32'h20, "R6 event beats clear");

        // R10 enables
        wr(8'h10, 32'h00);
        #3; chk("R10 irq masked", {31'h0, irq}, 32'h0); step();
        wr(8'h10, 32'h10);
        #3; chk("R10 rxof enable", {31'h0, irq}, 32'h1); step();

        // second transfer
        wr(8'h0C, 32'h3F);
        wr(8'h08, 32'h0007_0001);
        repeat (3) step();
        eng_done = 1; step(); eng_done = 0;
        wr(8'h10, 32'h01);
        repeat (3) step();
        finish_run();
    end
endmodule